// File: doc/BRIEF.md
# Accumulator Byte ALU with Arithmetic Flags

This block is the arithmetic and logic stage of an 8-bit accumulator machine. It handles three operation families: plain addition, addition that also takes in the incoming carry, and bitwise AND. Each cycle it receives an opcode, the accumulator value, the fetched source byte and the machine's current carry flag. When enabled and given a supported opcode, it registers the write-back result together with the carry (out of the top bit), auxiliary carry (out of bit 3) and overflow flags. An AND instruction writes back only the result. The flag registers keep their previous values.

The block also decodes the low four opcode bits into the source addressing mode, plus a register index. The operand-fetch logic sits outside the block and uses these to supply the source byte. When the target of an AND is an output port, the fetch logic must supply the port's output latch value rather than the pin value. This block only consumes the byte it is given.

Top module: `acc_alu`

## Requirements
- R1: With opcode upper nibble 0x2 (add), the enabled edge loads `res_q` with (acc_in + src_in) modulo 256.
- R2: With opcode upper nibble 0x3 (add with carry), the enabled edge loads `res_q` with (acc_in + src_in + cy_in) modulo 256.
- R3: For both add families, `cy_q` becomes the carry out of bit 7 of the sum.
- R4: For both add families, `ac_q` becomes the carry out of bit 3 (the low-nibble sum including any carry-in exceeds 15).
- R5: For both add families, `ov_q` becomes the exclusive OR of the carries out of bits 6 and 7.
- R6: With opcode upper nibble 0x5 (AND), the enabled edge loads `res_q` with acc_in & src_in, and `cy_q`, `ac_q` and `ov_q` keep their previous values.
- R7: `src_mode` decodes opcode bits 3..0 combinationally. 1rrr gives 0 (register, `reg_idx` = rrr). 0101 gives 1 (direct). 011i gives 2 (indirect, `reg_idx` = 00i). 0100 gives 3 (immediate).
- R8: `invalid` is high when the upper nibble is not 0x2, 0x3 or 0x5, or the low nibble is 0x0 to 0x3. On such an opcode no register or flag changes.
- R9: With `en` low, `res_q` and all flags hold their values.
- R10: After reset, `res_q`, `cy_q`, `ac_q` and `ov_q` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Execute the presented opcode on this edge |
| opcode | input | 8 | Instruction opcode byte |
| acc_in | input | 8 | Current accumulator value |
| src_in | input | 8 | Fetched source operand byte |
| cy_in | input | 1 | Current carry flag |
| src_mode | output | 2 | Decoded source addressing mode |
| reg_idx | output | 3 | Register index for register or indirect mode |
| invalid | output | 1 | Opcode not supported |
| res_q | output | 8 | Registered write-back result |
| cy_q | output | 1 | Registered carry flag |
| ac_q | output | 1 | Registered auxiliary-carry flag |
| ov_q | output | 1 | Registered overflow flag |

## Verification
Directed operands first. C3h with AAh under add and under add-with-carry checks the case where the sum carries out of bit 7 but not bit 6, which sets overflow. 0Fh plus 01h isolates the auxiliary carry. 7Fh plus 01h gives overflow without a carry, and FFh plus 01h gives a carry without overflow. These separate the three flags from one another. An AND after flag-setting adds shows that the flags are held. Seeded random opcodes, including unsupported ones, with random enables and carries, compare every mode decode and register update against a bench model. This separates execution from holding.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
   typedef enum logic [1:0] {
      OPK_ADD  = 2'd0,
      OPK_ADDC = 2'd1,
      OPK_AND  = 2'd2,
      OPK_NONE = 2'd3
   } op_kind_e;

   typedef enum logic [1:0] {
      SRC_REG  = 2'd0,
      SRC_DIR  = 2'd1,
      SRC_IND  = 2'd2,
      SRC_IMM  = 2'd3
   } src_mode_e;

   localparam logic [3:0] NIB_ADD  = 4'h2;
   localparam logic [3:0] NIB_ADDC = 4'h3;
   localparam logic [3:0] NIB_AND  = 4'h5;
endpackage

// File: rtl/acc_alu_decode.sv
module acc_alu_decode
   import acc_alu_pkg::*;
#(
   parameter int OPC_W = 8,
   parameter int IDX_W = 3
) (
   input  logic [OPC_W-1:0] opcode,
   output op_kind_e         kind,
   output src_mode_e        mode,
   output logic [IDX_W-1:0] idx,
   output logic             bad
);
   localparam int HI_LSB = OPC_W - 4;

   if (OPC_W != 8) begin : g_bad_opc
      $error("acc_alu_decode: OPC_W must be 8");
   end
   if (IDX_W != 3) begin : g_bad_idx
      $error("acc_alu_decode: IDX_W must be 3");
   end

   logic [3:0] hi_nib;
   logic [3:0] lo_nib;
   logic       mode_ok;

   assign hi_nib = opcode[OPC_W-1:HI_LSB];
   assign lo_nib = opcode[3:0];

   always_comb begin
      mode    = SRC_REG;
      idx     = '0;
      mode_ok = 1'b1;
      if (lo_nib[3]) begin
         mode = SRC_REG;
         idx  = lo_nib[2:0];
      end else if (lo_nib[2:1] == 2'b11) begin
         mode = SRC_IND;
         idx  = {2'b00, lo_nib[0]};
      end else if (lo_nib[2:0] == 3'b101) begin
         mode = SRC_DIR;
      end else if (lo_nib[2:0] == 3'b100) begin
         mode = SRC_IMM;
      end else begin
         mode_ok = 1'b0;
      end
   end

   always_comb begin
      unique case (hi_nib)
         NIB_ADD:  kind = OPK_ADD;
         NIB_ADDC: kind = OPK_ADDC;
         NIB_AND:  kind = OPK_AND;
         default:  kind = OPK_NONE;
      endcase
      if (!mode_ok) kind = OPK_NONE;
   end

   assign bad = (kind == OPK_NONE);
endmodule

// File: rtl/acc_alu_adder.sv
module acc_alu_adder #(
   parameter int W       = 8,
   parameter int AUX_POS = 4,
   parameter bit RIPPLE  = 1'b1
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         c_aux,
   output logic         c_sign,
   output logic         c_out
);
   localparam int MID_W = W - 1 - AUX_POS;

   if (AUX_POS < 1 || AUX_POS > W - 2) begin : g_bad_aux
      $error("acc_alu_adder: AUX_POS out of range");
   end

   if (RIPPLE) begin : g_ripple
      logic [W:0] cc;
      assign cc[0] = cin;
      for (genvar i = 0; i < W; i++) begin : g_bit
         assign sum[i]  = a[i] ^ b[i] ^ cc[i];
         assign cc[i+1] = (a[i] & b[i]) | (cc[i] & (a[i] ^ b[i]));
      end
      assign c_aux  = cc[AUX_POS];
      assign c_sign = cc[W-1];
      assign c_out  = cc[W];
   end else begin : g_segment
      logic [AUX_POS:0] lo;
      logic [MID_W:0]   mid;
      logic [1:0]       top;
      assign lo  = {1'b0, a[AUX_POS-1:0]} + {1'b0, b[AUX_POS-1:0]} + {{AUX_POS{1'b0}}, cin};
      assign mid = {1'b0, a[W-2:AUX_POS]} + {1'b0, b[W-2:AUX_POS]} + {{MID_W{1'b0}}, lo[AUX_POS]};
      assign top = {1'b0, a[W-1]} + {1'b0, b[W-1]} + {1'b0, mid[MID_W]};
      assign sum    = {top[0], mid[MID_W-1:0], lo[AUX_POS-1:0]};
      assign c_aux  = lo[AUX_POS];
      assign c_sign = mid[MID_W];
      assign c_out  = top[1];
   end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
   import acc_alu_pkg::*;
#(
   parameter int W       = 8,
   parameter int AUX_POS = 4,
   parameter bit RIPPLE  = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic [7:0]   opcode,
   input  logic [W-1:0] acc_in,
   input  logic [W-1:0] src_in,
   input  logic         cy_in,
   output logic [1:0]   src_mode,
   output logic [2:0]   reg_idx,
   output logic         invalid,
   output logic [W-1:0] res_q,
   output logic         cy_q,
   output logic         ac_q,
   output logic         ov_q
);
   if (W < 4) begin : g_bad_w
      $error("acc_alu: W must be at least 4");
   end

   op_kind_e     kind;
   src_mode_e    mode;
   logic [W-1:0] sum;
   logic         c_aux, c_sign, c_out;
   logic         add_cin;
   logic         is_add;
   logic         fire;
   logic [W-1:0] res_d;

   acc_alu_decode #(.OPC_W(8), .IDX_W(3)) u_dec (
      .opcode (opcode),
      .kind   (kind),
      .mode   (mode),
      .idx    (reg_idx),
      .bad    (invalid)
   );

   assign add_cin = (kind == OPK_ADDC) & cy_in;

   acc_alu_adder #(.W(W), .AUX_POS(AUX_POS), .RIPPLE(RIPPLE)) u_add (
      .a      (acc_in),
      .b      (src_in),
      .cin    (add_cin),
      .sum    (sum),
      .c_aux  (c_aux),
      .c_sign (c_sign),
      .c_out  (c_out)
   );

   assign src_mode = mode;
   assign is_add   = (kind == OPK_ADD) || (kind == OPK_ADDC);
   assign fire     = en & ~invalid;
   assign res_d    = (kind == OPK_AND) ? (acc_in & src_in) : sum;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_q <= '0;
         cy_q  <= 1'b0;
         ac_q  <= 1'b0;
         ov_q  <= 1'b0;
      end else if (fire) begin
         res_q <= res_d;
         if (is_add) begin
            cy_q <= c_out;
            ac_q <= c_aux;
            ov_q <= c_out ^ c_sign;
         end
      end
   end
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
   parameter int W = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic         en,
   input logic [7:0]   opcode,
   input logic [W-1:0] acc_in,
   input logic [W-1:0] src_in,
   input logic [1:0]   src_mode,
   input logic         invalid,
   input logic [W-1:0] res_q,
   input logic         cy_q,
   input logic         ac_q,
   input logic         ov_q
);
   assert_add_sum_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !invalid && opcode[7:4] == 4'h2) |=> res_q == W'($past(acc_in) + $past(src_in)));

   assert_and_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !invalid && opcode[7:4] == 4'h5) |=> res_q == ($past(acc_in) & $past(src_in)));

   assert_and_flags_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !invalid && opcode[7:4] == 4'h5) |=> ($stable(cy_q) && $stable(ac_q) && $stable(ov_q)));

   assert_reg_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!invalid && opcode[3]) |-> src_mode == 2'd0);

   assert_invalid_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      invalid |=> ($stable(res_q) && $stable(cy_q) && $stable(ac_q) && $stable(ov_q)));

   assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> ($stable(res_q) && $stable(cy_q) && $stable(ac_q) && $stable(ov_q)));
endmodule

bind acc_alu acc_alu_chk #(.W(W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .en       (en),
   .opcode   (opcode),
   .acc_in   (acc_in),
   .src_in   (src_in),
   .src_mode (src_mode),
   .invalid  (invalid),
   .res_q    (res_q),
   .cy_q     (cy_q),
   .ac_q     (ac_q),
   .ov_q     (ov_q)
);

// File: tb/test_acc_alu.sv
module test_acc_alu;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic [7:0] opcode = 8'h00;
   logic [7:0] acc_in = 8'h00;
   logic [7:0] src_in = 8'h00;
   logic       cy_in = 1'b0;
   logic [1:0] src_mode;
   logic [2:0] reg_idx;
   logic       invalid;
   logic [7:0] res_q;
   logic       cy_q, ac_q, ov_q;

   int n_chk = 0;
   int n_bad = 0;

   logic [7:0] m_res = 8'h00;
   logic       m_cy = 1'b0, m_ac = 1'b0, m_ov = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   acc_alu i_acc_alu (
      .clk(clk), .rst_n(rst_n), .en(en), .opcode(opcode), .acc_in(acc_in),
      .src_in(src_in), .cy_in(cy_in), .src_mode(src_mode), .reg_idx(reg_idx),
      .invalid(invalid), .res_q(res_q), .cy_q(cy_q), .ac_q(ac_q), .ov_q(ov_q)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic exp_bad(input logic [7:0] op);
      logic hi_ok;
      hi_ok = (op[7:4] == 4'h2) || (op[7:4] == 4'h3) || (op[7:4] == 4'h5);
      return !hi_ok || (op[3:0] < 4'h4);
   endfunction

   function automatic logic [4:0] exp_mode(input logic [7:0] op);
      if (op[3])              return {2'd0, op[2:0]};
      else if (op[3:0] == 5)  return {2'd1, 3'd0};
      else if (op[3:1] == 3)  return {2'd2, 2'b00, op[0]};
      else                    return {2'd3, 3'd0};
   endfunction

   task automatic model_step(input logic [7:0] op, input logic [7:0] a, input logic [7:0] b,
                             input logic c, input logic e);
      logic [8:0] full;
      logic [4:0] lo;
      logic [7:0] six;
      logic       ci;
      if (!e || exp_bad(op)) return;
      if (op[7:4] == 4'h5) begin
         m_res = a & b;
         return;
      end
      ci   = (op[7:4] == 4'h3) ? c : 1'b0;
      full = {1'b0, a} + {1'b0, b} + {8'd0, ci};
      lo   = {1'b0, a[3:0]} + {1'b0, b[3:0]} + {4'd0, ci};
      six  = {1'b0, a[6:0]} + {1'b0, b[6:0]} + {7'd0, ci};
      m_res = full[7:0];
      m_cy  = full[8];
      m_ac  = lo[4];
      m_ov  = full[8] ^ six[7];
   endtask

   task automatic step(input logic [7:0] op, input logic [7:0] a, input logic [7:0] b,
                       input logic c, input logic e, input string tag);
      opcode = op; acc_in = a; src_in = b; cy_in = c; en = e;
      #1;
      chk({tag, " R8 invalid"}, invalid, exp_bad(op));
      if (!exp_bad(op)) chk({tag, " R7 mode/idx"}, {src_mode, reg_idx}, exp_mode(op));
      model_step(op, a, b, c, e);
      @(negedge clk);
      chk({tag, " R1 R2 R6 res"}, res_q, m_res);
      chk({tag, " R3 cy"}, cy_q, m_cy);
      chk({tag, " R4 ac"}, ac_q, m_ac);
      chk({tag, " R5 ov"}, ov_q, m_ov);
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (2) @(negedge clk);
      chk("R10 reset res", res_q, 8'h00);
      chk("R10 reset flags", {cy_q, ac_q, ov_q}, 3'b000);
      rst_n = 1'b1;
      @(negedge clk);
      step(8'h28, 8'hC3, 8'hAA, 1'b0, 1'b1, "R1 add C3+AA");
      chk("R1 add C3+AA = 6D", res_q, 8'h6D);
      chk("R3 R5 R4 C3+AA flags", {cy_q, ov_q, ac_q}, 3'b110);
      step(8'h38, 8'hC3, 8'hAA, 1'b1, 1'b1, "R2 addc C3+AA+1");
      chk("R2 addc = 6E", res_q, 8'h6E);
      step(8'h54, 8'hC3, 8'h55, 1'b0, 1'b1, "R6 and");
      chk("R6 C3&55 = 41", res_q, 8'h41);
      chk("R6 flags held", {cy_q, ov_q, ac_q}, 3'b110);
      step(8'h24, 8'h0F, 8'h01, 1'b0, 1'b1, "R4 aux only");
      chk("R4 0F+01 flags", {cy_q, ac_q, ov_q}, 3'b010);
      step(8'h25, 8'h7F, 8'h01, 1'b0, 1'b1, "R5 ov only");
      chk("R5 7F+01 flags", {cy_q, ov_q}, 2'b01);
      step(8'h26, 8'hFF, 8'h01, 1'b0, 1'b1, "R3 cy no ov");
      chk("R3 FF+01 flags", {cy_q, ov_q, res_q}, {2'b10, 8'h00});
      step(8'h21, 8'h55, 8'h55, 1'b1, 1'b1, "R8 bad low nibble");
      chk("R8 result held", res_q, 8'h00);
      step(8'h48, 8'h55, 8'h55, 1'b1, 1'b1, "R8 bad high nibble");
      step(8'h2F, 8'h12, 8'h34, 1'b0, 1'b0, "R9 en low");
      chk("R9 held", res_q, 8'h00);
      step(8'h57, 8'hF0, 8'h3C, 1'b0, 1'b1, "R7 indirect");
      step(8'h35, 8'h01, 8'h02, 1'b1, 1'b1, "R7 direct");
      for (int i = 0; i < 400; i++) begin
         logic [7:0] op;
         logic [31:0] r;
         r  = $urandom;
         case (r[1:0])
            2'd0: op = {4'h2, r[7:4]};
            2'd1: op = {4'h3, r[7:4]};
            2'd2: op = {4'h5, r[7:4]};
            default: op = r[15:8];
         endcase
         step(op, 8'($urandom), 8'($urandom), r[16], (r[19:17] != 3'd0), "random");
      end
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule